// File: doc/BRIEF.md
# Asynchronous Host Bus Slave Port

This block attaches a register file to a host bus that uses plain, unclocked read and write strobes. The host drives a halfword address, an address-enable qualifier, four active-low byte-lane enables, an active-low address strobe, active-low read and write strobes and an active-low chip select for the data register. Every access moves exactly one data item; there are no bursts. The strobes are synchronized into an internal clock, which paces wait-state generation and the register-file write port.

Three attachment styles are supported. In the first, the address strobe is tied low, the address path is transparent, and the host keeps the address stable for the whole cycle. In the second, the rising edge of the address strobe captures the address, address enable and byte enables, so the host may change them afterwards. In the third, the data chip select bypasses the local decoder and reaches only the data register, always as a full 32-bit word. A combinational decoder compares the (possibly latched) address bits [15:4] and the address enable against a base tag and drives an active-low device-select output.

Write requests leave on a valid/ready port. `rf_wr_valid` rises with index, lanes and data, and all four stay unchanged until a cycle in which `rf_wr_ready` is high. While a request waits, the host is held off with wait states on the ready output. Reads use a combinational index-out/data-in port. The read data bus is enabled only while the read strobe is low and the access is targeted.

Top module: `hbus_async_slave`

## Requirements
- R1: During and right after reset, `bus_ardy_n` is 1, `rf_wr_valid` is 0 and `bus_rdata_oe` is 0.
- R2: With `bus_ads_n` held low, `bus_devsel_n` is 0 exactly when `bus_aen` is 0 and `bus_addr[15:4]` equals `BASE_TAG`, and it follows address changes without any clock.
- R3: After a rising edge of `bus_ads_n`, and while it stays high, the address, address enable and byte enables captured at that edge set the decode, the register index and the lanes; later changes on those pins have no effect.
- R4: A rising edge of `bus_wr_n` on a decoded access gives one write request within 3 clocks, with `rf_wr_idx` = address bits [3:1], `rf_wr_be` = the inverted byte enables (bit i for lane i) and `rf_wr_data` = `bus_wdata`. The host holds address, selects and data for 3 clocks after the edge.
- R5: A write strobe with the device not decoded (`bus_aen` = 1 or a tag mismatch) and `bus_dcs_n` high makes no write request.
- R6: A write with `bus_dcs_n` low targets index `DATA_IDX` (default 0) with `rf_wr_be` = 4'b1111, whatever the address, address enable and byte enables are.
- R7: A read with `bus_dcs_n` low presents index `DATA_IDX` on `rf_rd_idx` and drives the bus, even when the decoder does not select the device.
- R8: While `bus_rd_n` is low on a targeted access, `bus_rdata_oe` is 1, `rf_rd_idx` is address bits [3:1] and `bus_rdata` equals `rf_rd_data`. Otherwise `bus_rdata_oe` is 0.
- R9: A falling edge on either strobe of a targeted access pulls `bus_ardy_n` low for exactly `WAIT_CYCLES` (default 3) clocks, starting within 3 clocks. An untargeted strobe causes no wait state.
- R10: While `rf_wr_valid` is 1 and `rf_wr_ready` is 0, index, lanes and data stay stable and `bus_ardy_n` is 0.
- R11: Each write strobe gives at most one request, and it is accepted exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 15 | Host address bits [15:1] |
| bus_aen | input | 1 | Address enable; 0 qualifies the decode |
| bus_be_n | input | 4 | Active-low byte-lane enables |
| bus_ads_n | input | 1 | Address strobe; tie low for transparent address |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_dcs_n | input | 1 | Data register chip select, active low |
| bus_wdata | input | 32 | Write data from host |
| bus_rdata | output | 32 | Read data to host |
| bus_rdata_oe | output | 1 | Output enable for the read data pad |
| bus_devsel_n | output | 1 | Local decode result, active low |
| bus_ardy_n | output | 1 | Ready, low to insert wait states |
| rf_wr_valid | output | 1 | Write request valid |
| rf_wr_ready | input | 1 | Register file accepts the request |
| rf_wr_idx | output | 3 | Write register index |
| rf_wr_be | output | 4 | Write byte lanes, active high |
| rf_wr_data | output | 32 | Write data |
| rf_rd_idx | output | 3 | Read register index |
| rf_rd_data | input | 32 | Read data from register file |

## Verification
Writes are driven three ways: with a transparent address, with an address latched and then scrambled, and through the chip select with a scrambled address and partial byte enables. The matching scoreboard entries show whether the index and lanes come from the live pins, from the latch, or are forced to the data register and full word. Strobes with the address enable high and with a wrong tag must leave the scoreboard untouched and produce no wait state, which separates the decode qualifiers from each other. A stalled `rf_wr_ready` and two writes back to back show that back-pressure stretches the cycle and that each strobe gives exactly one request.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  parameter int unsigned DATA_W = 32;
  parameter int unsigned ADDR_HI = 15;
  parameter int unsigned IDX_W = 3;
  localparam int unsigned BE_W = DATA_W / 8;
  localparam int unsigned TAG_W = ADDR_HI - IDX_W;

  typedef struct packed {
    logic [IDX_W-1:0]  idx;
    logic [BE_W-1:0]   be;
    logic [DATA_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/hbus_addr_front.sv
module hbus_addr_front
  import hbus_pkg::*;
#(
  parameter logic [TAG_W-1:0] BASE_TAG = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_HI:1]   addr_i,
  input  logic               aen_i,
  input  logic [BE_W-1:0]    be_n_i,
  input  logic               ads_n_i,
  output logic [ADDR_HI:1]   addr_o,
  output logic [BE_W-1:0]    be_n_o,
  output logic               sel_o
);
  logic [ADDR_HI:1] addr_q;
  logic             aen_q;
  logic [BE_W-1:0]  be_n_q;

  // Transparent while the strobe is low, holds from its rising edge on.
  always_latch begin
    if (!ads_n_i) begin
      addr_q = addr_i;
      aen_q  = aen_i;
      be_n_q = be_n_i;
    end
  end

  assign addr_o = addr_q;
  assign be_n_o = be_n_q;
  assign sel_o  = !aen_q && (addr_q[ADDR_HI:IDX_W+1] == BASE_TAG);

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ads_n_i && $past(ads_n_i)) |-> ($stable(addr_o) && $stable(be_n_o) && $stable(sel_o)));
endmodule

// File: rtl/hbus_edge_sync.sv
module hbus_edge_sync #(
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] strobe_n_i,
  output logic [LANES-1:0] rise_o,
  output logic [LANES-1:0] fall_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= strobe_n_i[g];
        s2_q <= s1_q;
      end
    end
    assign rise_o[g] = s1_q && !s2_q;
    assign fall_o[g] = !s1_q && s2_q;

    // R11
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/hbus_wait_gen.sv
module hbus_wait_gen #(
  parameter int unsigned WAIT_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  if (WAIT_CYCLES == 0) begin : g_none
    assign busy_o = 1'b0;
  end else begin : g_cnt
    localparam int unsigned CNT_W = $clog2(WAIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(WAIT_CYCLES);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (start_i)         cnt_q <= LOAD;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end
    assign busy_o = (cnt_q != '0);

    // R9
    wait_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (busy_o && cnt_q == LOAD));
    // R9
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LOAD);
  end
endmodule

// File: rtl/hbus_async_slave.sv
module hbus_async_slave
  import hbus_pkg::*;
#(
  parameter logic [TAG_W-1:0] BASE_TAG    = 12'h030,
  parameter int unsigned      DATA_IDX    = 0,
  parameter int unsigned      WAIT_CYCLES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_HI:1]   bus_addr,
  input  logic               bus_aen,
  input  logic [BE_W-1:0]    bus_be_n,
  input  logic               bus_ads_n,
  input  logic               bus_rd_n,
  input  logic               bus_wr_n,
  input  logic               bus_dcs_n,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_rdata_oe,
  output logic               bus_devsel_n,
  output logic               bus_ardy_n,
  output logic               rf_wr_valid,
  input  logic               rf_wr_ready,
  output logic [IDX_W-1:0]   rf_wr_idx,
  output logic [BE_W-1:0]    rf_wr_be,
  output logic [DATA_W-1:0]  rf_wr_data,
  output logic [IDX_W-1:0]   rf_rd_idx,
  input  logic [DATA_W-1:0]  rf_rd_data
);
  localparam int unsigned RD = 0;
  localparam int unsigned WR = 1;
  localparam logic [IDX_W-1:0] DATA_SLOT = IDX_W'(DATA_IDX);

  logic [ADDR_HI:1] lat_addr;
  logic [BE_W-1:0]  lat_be_n;
  logic             dec_sel;
  logic             dcs_act, target;
  logic [IDX_W-1:0] cur_idx;
  logic [BE_W-1:0]  cur_be;
  logic [1:0]       rise, fall;
  logic             wait_busy, wait_start;
  logic             pend_q, take;
  wr_req_t          req_q;

  hbus_addr_front #(.BASE_TAG(BASE_TAG)) front_i (
    .clk(clk), .rst_n(rst_n),
    .addr_i(bus_addr), .aen_i(bus_aen), .be_n_i(bus_be_n), .ads_n_i(bus_ads_n),
    .addr_o(lat_addr), .be_n_o(lat_be_n), .sel_o(dec_sel)
  );

  hbus_edge_sync #(.LANES(2)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .strobe_n_i({bus_wr_n, bus_rd_n}),
    .rise_o(rise), .fall_o(fall)
  );

  // Chip select wins over the local decoder and pins the data register.
  assign dcs_act = !bus_dcs_n;
  assign target  = dcs_act || dec_sel;
  assign cur_idx = dcs_act ? DATA_SLOT : lat_addr[IDX_W:1];
  assign cur_be  = dcs_act ? {BE_W{1'b1}} : ~lat_be_n;

  assign wait_start = (fall[RD] || fall[WR]) && target;

  hbus_wait_gen #(.WAIT_CYCLES(WAIT_CYCLES)) wait_i (
    .clk(clk), .rst_n(rst_n), .start_i(wait_start), .busy_o(wait_busy)
  );

  assign take = rise[WR] && target && (!pend_q || rf_wr_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      req_q  <= '0;
    end else begin
      if (pend_q && rf_wr_ready) pend_q <= 1'b0;
      if (take) begin
        pend_q     <= 1'b1;
        req_q.idx  <= cur_idx;
        req_q.be   <= cur_be;
        req_q.data <= bus_wdata;
      end
    end
  end

  assign rf_wr_valid  = pend_q;
  assign rf_wr_idx    = req_q.idx;
  assign rf_wr_be     = req_q.be;
  assign rf_wr_data   = req_q.data;

  assign bus_ardy_n   = !(wait_busy || pend_q);
  assign bus_devsel_n = !dec_sel;
  assign rf_rd_idx    = cur_idx;
  assign bus_rdata_oe = !bus_rd_n && target;
  assign bus_rdata    = bus_rdata_oe ? rf_rd_data : '0;

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr_valid && !rf_wr_ready) |=>
      (rf_wr_valid && $stable(rf_wr_idx) && $stable(rf_wr_be) && $stable(rf_wr_data)));
  // R10
  stall_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_valid |-> !bus_ardy_n);
  // R6
  dcs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[WR] && !bus_dcs_n && !pend_q) |=>
      (rf_wr_valid && rf_wr_idx == DATA_SLOT && rf_wr_be == {BE_W{1'b1}}));
  // R8
  oe_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_oe |-> !bus_rd_n);
  // R5
  no_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[WR] && bus_dcs_n && bus_devsel_n && !rf_wr_valid) |=> !rf_wr_valid);
endmodule

// File: tb/hbus_async_slave_tb.sv
`timescale 1ns/1ps
module hbus_async_slave_tb_top;
  localparam logic [11:0] TAG = 12'h030;
  localparam int WAITS = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:1] bus_addr = '0;
  logic        bus_aen = 1'b1;
  logic [3:0]  bus_be_n = 4'hF;
  logic        bus_ads_n = 1'b0;
  logic        bus_rd_n = 1'b1;
  logic        bus_wr_n = 1'b1;
  logic        bus_dcs_n = 1'b1;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rdata_oe, bus_devsel_n, bus_ardy_n;
  logic        rf_wr_valid;
  logic        rf_wr_ready = 1'b1;
  logic [2:0]  rf_wr_idx, rf_rd_idx;
  logic [3:0]  rf_wr_be;
  logic [31:0] rf_wr_data, rf_rd_data;

  int checks = 0;
  int failures = 0;
  logic [38:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  assign rf_rd_data = 32'hC0DE_0000 | {29'd0, rf_rd_idx} << 4;

  hbus_async_slave #(.BASE_TAG(TAG), .DATA_IDX(0), .WAIT_CYCLES(WAITS)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_aen(bus_aen),
    .bus_be_n(bus_be_n), .bus_ads_n(bus_ads_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_dcs_n(bus_dcs_n), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe), .bus_devsel_n(bus_devsel_n),
    .bus_ardy_n(bus_ardy_n), .rf_wr_valid(rf_wr_valid), .rf_wr_ready(rf_wr_ready),
    .rf_wr_idx(rf_wr_idx), .rf_wr_be(rf_wr_be), .rf_wr_data(rf_wr_data),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data)
  );

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Scoreboard monitor: every accepted request must match the head of the queue.
  always @(negedge clk) begin
    if (rst_n && rf_wr_valid && rf_wr_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", "unexpected write idx", {29'd0, rf_wr_idx}, 32'hFFFF_FFFF);
      end else begin
        logic [38:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({rf_wr_idx, rf_wr_be, rf_wr_data} == e, t, "write request",
              rf_wr_data, e[31:0]);
        check(rf_wr_idx == e[38:36] && rf_wr_be == e[35:32], t, "write idx/lanes",
              {25'd0, rf_wr_idx, rf_wr_be}, {25'd0, e[38:32]});
      end
    end
  end

  function automatic logic [15:1] mk_addr(logic [11:0] t, logic [2:0] idx);
    return {t, idx};
  endfunction

  // Drive a whole write cycle; count wait-state clocks while the strobe is low.
  task automatic host_write(logic [15:1] a, logic aen, logic [3:0] be_n, logic dcs_n,
                            logic [31:0] d, bit latch, int exp_wait, string req);
    int lows = 0;
    @(negedge clk);
    bus_addr = a; bus_aen = aen; bus_be_n = be_n; bus_dcs_n = dcs_n; bus_wdata = d;
    if (latch) begin
      bus_ads_n = 1'b0;
      @(negedge clk);
      bus_ads_n = 1'b1;
      @(negedge clk);
      bus_addr = ~a; bus_aen = 1'b1; bus_be_n = ~be_n;
      #0.1;
      // R3: decode unaffected by scrambled pins
      check(bus_devsel_n == (aen || a[15:4] != TAG), "R3", "latched devsel",
            {31'd0, bus_devsel_n}, {31'd0, (aen || a[15:4] != TAG)});
    end
    @(negedge clk);
    bus_wr_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!bus_ardy_n) lows++;
    end
    check(lows == exp_wait, (exp_wait == 0) ? "R9" : req, "wait clocks",
          lows, exp_wait);
    bus_wr_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_dcs_n = 1'b1; bus_aen = 1'b1; bus_ads_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_wr(logic [2:0] idx, logic [3:0] be, logic [31:0] d, string req);
    exp_q.push_back({idx, be, d});
    tag_q.push_back(req);
  endtask

  task automatic host_read(logic [15:1] a, logic aen, logic dcs_n, bit exp_oe,
                           logic [2:0] exp_idx, string req);
    @(negedge clk);
    bus_addr = a; bus_aen = aen; bus_dcs_n = dcs_n;
    @(negedge clk);
    bus_rd_n = 1'b0;
    repeat (2) @(negedge clk);
    check(bus_rdata_oe == exp_oe, req, "read oe", {31'd0, bus_rdata_oe}, {31'd0, exp_oe});
    if (exp_oe) begin
      check(rf_rd_idx == exp_idx, req, "read idx", {29'd0, rf_rd_idx}, {29'd0, exp_idx});
      check(bus_rdata == (32'hC0DE_0000 | {29'd0, exp_idx} << 4), req, "read data",
            bus_rdata, 32'hC0DE_0000 | {29'd0, exp_idx} << 4);
    end
    bus_rd_n = 1'b1;
    repeat (5) @(negedge clk);
    check(bus_rdata_oe == 1'b0, "R8", "oe after strobe", {31'd0, bus_rdata_oe}, 32'd0);
    bus_dcs_n = 1'b1; bus_aen = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(bus_ardy_n == 1'b1, "R1", "ardy in reset", {31'd0, bus_ardy_n}, 32'd1);
    check(rf_wr_valid == 1'b0, "R1", "valid in reset", {31'd0, rf_wr_valid}, 32'd0);
    check(bus_rdata_oe == 1'b0, "R1", "oe in reset", {31'd0, bus_rdata_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(bus_ardy_n == 1'b1 && !rf_wr_valid, "R1", "idle after reset",
          {30'd0, bus_ardy_n, rf_wr_valid}, 32'd2);

    // R2: transparent decode
    bus_addr = mk_addr(TAG, 3'd1); bus_aen = 1'b0; #0.1;
    check(bus_devsel_n == 1'b0, "R2", "match", {31'd0, bus_devsel_n}, 32'd0);
    bus_aen = 1'b1; #0.1;
    check(bus_devsel_n == 1'b1, "R2", "aen high", {31'd0, bus_devsel_n}, 32'd1);
    bus_aen = 1'b0; bus_addr = mk_addr(TAG ^ 12'h100, 3'd1); #0.1;
    check(bus_devsel_n == 1'b1, "R2", "tag miss", {31'd0, bus_devsel_n}, 32'd1);
    bus_aen = 1'b1;

    // R4: transparent write, lanes 0 and 2
    expect_wr(3'd5, 4'b0101, 32'h1234_5678, "R4");
    host_write(mk_addr(TAG, 3'd5), 1'b0, 4'b1010, 1'b1, 32'h1234_5678, 1'b0, WAITS, "R9");

    // R3: latched write, pins scrambled before the strobe
    expect_wr(3'd2, 4'b1100, 32'hA5A5_0F0F, "R3");
    host_write(mk_addr(TAG, 3'd2), 1'b0, 4'b0011, 1'b1, 32'hA5A5_0F0F, 1'b1, WAITS, "R9");

    // R6: chip select write with undecoded address and partial lanes
    expect_wr(3'd0, 4'b1111, 32'hDEAD_BEEF, "R6");
    host_write(mk_addr(12'hFFF, 3'd6), 1'b1, 4'b0110, 1'b0, 32'hDEAD_BEEF, 1'b0, WAITS, "R6");

    // R5: deselected writes (aen high, then wrong tag) leave no request
    host_write(mk_addr(TAG, 3'd3), 1'b1, 4'b0000, 1'b1, 32'h0BAD_0001, 1'b0, 0, "R5");
    host_write(mk_addr(TAG ^ 12'h001, 3'd3), 1'b0, 4'b0000, 1'b1, 32'h0BAD_0002, 1'b0, 0, "R5");
    check(exp_q.size() == 0, "R5", "queue drained", exp_q.size(), 32'd0);

    // R10: back-pressure holds the request and the wait state
    rf_wr_ready = 1'b0;
    expect_wr(3'd7, 4'b1111, 32'h7777_0007, "R10");
    fork
      host_write(mk_addr(TAG, 3'd7), 1'b0, 4'b0000, 1'b1, 32'h7777_0007, 1'b0, WAITS, "R9");
      begin
        repeat (16) @(negedge clk);
        check(rf_wr_valid == 1'b1, "R10", "valid held", {31'd0, rf_wr_valid}, 32'd1);
        check(bus_ardy_n == 1'b0, "R10", "ardy held low", {31'd0, bus_ardy_n}, 32'd0);
        check(rf_wr_data == 32'h7777_0007, "R10", "data held", rf_wr_data, 32'h7777_0007);
      end
    join
    rf_wr_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(bus_ardy_n == 1'b1, "R10", "ardy released", {31'd0, bus_ardy_n}, 32'd1);

    // R11: two writes back to back, one request each
    expect_wr(3'd1, 4'b0001, 32'h0000_0011, "R11");
    host_write(mk_addr(TAG, 3'd1), 1'b0, 4'b1110, 1'b1, 32'h0000_0011, 1'b0, WAITS, "R9");
    expect_wr(3'd4, 4'b1000, 32'h0000_0044, "R11");
    host_write(mk_addr(TAG, 3'd4), 1'b0, 4'b0111, 1'b1, 32'h0000_0044, 1'b0, WAITS, "R9");
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R11", "all requests seen once", exp_q.size(), 32'd0);
    check(rf_wr_valid == 1'b0, "R11", "no extra request", {31'd0, rf_wr_valid}, 32'd0);

    // R8, R7: reads
    host_read(mk_addr(TAG, 3'd3), 1'b0, 1'b1, 1'b1, 3'd3, "R8");
    host_read(mk_addr(TAG, 3'd6), 1'b1, 1'b1, 1'b0, 3'd0, "R8");
    host_read(mk_addr(12'h555, 3'd6), 1'b1, 1'b0, 1'b1, 3'd0, "R7");

    // R3: latched read after pins change
    @(negedge clk);
    bus_addr = mk_addr(TAG, 3'd6); bus_aen = 1'b0; bus_ads_n = 1'b0;
    @(negedge clk);
    bus_ads_n = 1'b1;
    @(negedge clk);
    bus_addr = mk_addr(12'h000, 3'd2); bus_aen = 1'b1;
    bus_rd_n = 1'b0;
    repeat (2) @(negedge clk);
    check(bus_rdata_oe && rf_rd_idx == 3'd6, "R3", "latched read idx",
          {28'd0, bus_rdata_oe, rf_rd_idx}, 32'hE);
    bus_rd_n = 1'b1; bus_ads_n = 1'b0;
    repeat (4) @(negedge clk);

    check(exp_q.size() == 0, "R4", "scoreboard empty", exp_q.size(), 32'd0);
    summary();
  end
endmodule